// File: doc/BRIEF.md
# DMA Command-Queue Register Stub

This block occupies a 4 KB register window and poses as a DMA engine that moves data between a host and a controller. Software sets up a command-queue base address, an end pointer and a write pointer. Whenever the write pointer is updated, the block treats every queued command as finished in that same access. It copies the write pointer into the read pointer, sets the upstream and downstream completion status bits, and raises a level interrupt if either completion is enabled. No data moves, and the block has no host-side port.

Only the first 31 words of the window are stored. Addresses above that read as zero and ignore writes. A special value written to the read-pointer register holds off the completion for the next write-pointer update only. The completion status bits are write-one-to-clear, and clearing them drops the interrupt. Access is through a simple 32-bit valid/ready register bus with byte addresses. The bus is always ready, and read data arrives one cycle after the request.

Top module: `dma_cmdq_stub`

## Requirements
- R1: After reset every stored word reads 0, except the status word at byte offset 0x24, which reads 0xF8000000. The interrupt output is low.
- R2: A write to the end pointer (offset 0x14) stores only bits 17:0 of the data, which is the data ANDed with 0x0003FFFF.
- R3: A write to the write pointer (offset 0x18) stores the data ANDed with 0x0003FFFF. The same value is also placed in the read pointer (offset 0x1C) by that same access.
- R4: A write to the read pointer never changes its stored value. Writing 0xEE882266 arms a one-shot suppress flag. Any other value has no effect.
- R5: A write-pointer write with the flag clear sets status bits 4 and 5. With the flag armed, it clears the flag and leaves the status unchanged.
- R6: A completion drives the interrupt high only when control bit 4 or bit 5 is set. The interrupt then stays high until it is cleared.
- R7: A write to the control register (offset 0x20) stores the data ANDed with 0xBFEFF07F.
- R8: A status write with bit 4 or bit 5 set clears both status bits 4 and 5 and drops the interrupt. All other bits of that write are ignored, and a status write with neither bit set changes nothing.
- R9: A write to any other stored offset below 0x7C, including the queue base at 0x10, stores all 32 bits.
- R10: Offsets from 0x7C up to 0xFFC read as 0, and writes to them change no stored state.
- R11: A read request is always accepted. Its data and response-valid appear one clock cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Bus request valid |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_addr_i | input | 12 | Byte address inside the window (bits 1:0 ignored) |
| req_wdata_i | input | 32 | Write data |
| req_ready_o | output | 1 | Request accepted (tied high) |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Level interrupt on enabled completion |

## Verification
A write takes effect at the clock edge that accepts it, and the registered interrupt changes at that same edge. A read returns its data and response-valid exactly one edge after it is accepted. The bench drives each request on a falling edge and samples the outputs on the next falling edge, so it checks each result in the single cycle where it is due. A reference model inside the bench applies the masks, the copy into the read pointer, the one-shot flag and the clearing rule after every write, and every read is compared against that model.

// File: rtl/dcq_pkg.sv
package dcq_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned W_ENDP = 5;
  localparam int unsigned W_WPTR = 6;
  localparam int unsigned W_RPTR = 7;
  localparam int unsigned W_CTRL = 8;
  localparam int unsigned W_STAT = 9;
  localparam int unsigned UP_BIT = 4;
  localparam int unsigned DN_BIT = 5;
  localparam logic [DATA_W-1:0] PTR_MASK  = 32'h0003_FFFF;
  localparam logic [DATA_W-1:0] CTRL_MASK = 32'hBFEF_F07F;
  localparam logic [DATA_W-1:0] STAT_RST  = 32'hF800_0000;
  localparam logic [DATA_W-1:0] HOLD_KEY  = 32'hEE88_2266;

  typedef struct packed {
    logic endp;
    logic wptr;
    logic rptr;
    logic ctrl;
    logic stat;
  } eng_sel_t;

  function automatic logic is_eng_word(input int unsigned w);
    return (w >= W_ENDP) && (w <= W_STAT);
  endfunction
endpackage

// File: rtl/dcq_decode.sv
module dcq_decode #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_WORDS = 31,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_range_o,
  output logic [IDX_W-1:0]  idx_o,
  output dcq_pkg::eng_sel_t sel_o,
  output logic              eng_hit_o
);
  import dcq_pkg::*;
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;

  assign word       = addr_i[ADDR_W-1:2];
  assign in_range_o = word < WORD_W'(NUM_WORDS);
  assign idx_o      = word[IDX_W-1:0];

  always_comb begin
    sel_o      = '0;
    sel_o.endp = in_range_o && (word == WORD_W'(W_ENDP));
    sel_o.wptr = in_range_o && (word == WORD_W'(W_WPTR));
    sel_o.rptr = in_range_o && (word == WORD_W'(W_RPTR));
    sel_o.ctrl = in_range_o && (word == WORD_W'(W_CTRL));
    sel_o.stat = in_range_o && (word == WORD_W'(W_STAT));
  end

  assign eng_hit_o = |sel_o;

  always_comb begin
    a_r10_sel_in_range: assert (!(eng_hit_o && !in_range_o));
    a_r10_sel_onehot:   assert ($onehot0(sel_o));
  end
endmodule

// File: rtl/dcq_regfile.sv
module dcq_regfile #(
  parameter int unsigned NUM_WORDS = 31,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [dcq_pkg::DATA_W-1:0] wdata_i,
  output logic [dcq_pkg::DATA_W-1:0] rdata_o
);
  import dcq_pkg::*;

  logic [NUM_WORDS-1:0][DATA_W-1:0] words;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    if (is_eng_word(i)) begin : g_eng
      assign words[i] = '0;
    end else begin : g_plain
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                 q <= '0;
        else if (we_i && (idx_i == IDX_W'(i)))       q <= wdata_i;
      end
      assign words[i] = q;
    end
  end

  assign rdata_o = (int'(idx_i) < NUM_WORDS) ? words[idx_i] : '0;
endmodule

// File: rtl/dcq_engine.sv
module dcq_engine (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  dcq_pkg::eng_sel_t          sel_i,
  input  logic [dcq_pkg::DATA_W-1:0] wdata_i,
  output logic [dcq_pkg::DATA_W-1:0] rdata_o,
  output logic                       irq_o
);
  import dcq_pkg::*;

  logic [DATA_W-1:0] endp_q, wptr_q, rptr_q, ctrl_q, stat_q;
  logic              hold_q, irq_q;
  logic [DATA_W-1:0] ptr_new;
  logic              done_en, stat_clr;

  assign ptr_new  = wdata_i & PTR_MASK;
  assign done_en  = ctrl_q[UP_BIT] | ctrl_q[DN_BIT];
  assign stat_clr = wdata_i[UP_BIT] | wdata_i[DN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      endp_q <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      ctrl_q <= '0;
      stat_q <= STAT_RST;
      hold_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (we_i) begin
      if (sel_i.endp) endp_q <= ptr_new;
      if (sel_i.wptr) begin
        wptr_q <= ptr_new;
        rptr_q <= ptr_new;  // all commands finish at once: queue empty
        if (hold_q) begin
          hold_q <= 1'b0;
        end else begin
          stat_q[UP_BIT] <= 1'b1;
          stat_q[DN_BIT] <= 1'b1;
          if (done_en) irq_q <= 1'b1;
        end
      end
      if (sel_i.rptr && (wdata_i == HOLD_KEY)) hold_q <= 1'b1;
      if (sel_i.ctrl) ctrl_q <= wdata_i & CTRL_MASK;
      if (sel_i.stat && stat_clr) begin
        stat_q[UP_BIT] <= 1'b0;
        stat_q[DN_BIT] <= 1'b0;
        irq_q          <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (1'b1)
      sel_i.endp: rdata_o = endp_q;
      sel_i.wptr: rdata_o = wptr_q;
      sel_i.rptr: rdata_o = rptr_q;
      sel_i.ctrl: rdata_o = ctrl_q;
      sel_i.stat: rdata_o = stat_q;
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o = irq_q;

  a_r3_rptr_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i.wptr) |=> (rptr_q == ($past(wdata_i) & PTR_MASK)));
  a_r4_rptr_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i.rptr) |=> $stable(rptr_q));
  a_r5_hold_suppresses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i.wptr && hold_q) |=> ($stable(stat_q) && $stable(irq_q) && !hold_q));
  a_r6_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(we_i && sel_i.wptr && done_en));
  a_r8_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i.stat && stat_clr) |=> (!irq_q && stat_q[DN_BIT:UP_BIT] == 2'b00));
  a_r7_ctrl_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q & ~CTRL_MASK) == '0);
endmodule

// File: rtl/dma_cmdq_stub.sv
module dma_cmdq_stub #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_WORDS = 31
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic                       req_write_i,
  input  logic [ADDR_W-1:0]          req_addr_i,
  input  logic [dcq_pkg::DATA_W-1:0] req_wdata_i,
  output logic                       req_ready_o,
  output logic                       rsp_valid_o,
  output logic [dcq_pkg::DATA_W-1:0] rsp_rdata_o,
  output logic                       irq_o
);
  import dcq_pkg::*;
  localparam int unsigned IDX_W = $clog2(NUM_WORDS);

  logic              in_range, eng_hit, wr_acc, rd_acc;
  logic [IDX_W-1:0]  idx;
  eng_sel_t          sel;
  logic [DATA_W-1:0] rf_rdata, eng_rdata, rd_mux;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  assign req_ready_o = 1'b1;
  assign wr_acc      = req_valid_i && req_write_i;
  assign rd_acc      = req_valid_i && !req_write_i;

  dcq_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_decode (
    .addr_i     (req_addr_i),
    .in_range_o (in_range),
    .idx_o      (idx),
    .sel_o      (sel),
    .eng_hit_o  (eng_hit)
  );

  dcq_regfile #(.NUM_WORDS(NUM_WORDS)) u_regfile (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_acc && in_range && !eng_hit),
    .idx_i   (idx),
    .wdata_i (req_wdata_i),
    .rdata_o (rf_rdata)
  );

  dcq_engine u_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_acc),
    .sel_i   (sel),
    .wdata_i (req_wdata_i),
    .rdata_o (eng_rdata),
    .irq_o   (irq_o)
  );

  assign rd_mux = !in_range ? '0 : (eng_hit ? eng_rdata : rf_rdata);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rd_acc;
      if (rd_acc) rsp_rdata_q <= rd_mux;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;

  a_r11_rsp_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc |=> rsp_valid_o);
  a_r11_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_acc |=> !rsp_valid_o);
  a_r10_oob_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && !in_range) |=> (rsp_rdata_o == '0));
endmodule

// File: tb/dma_cmdq_stub_tb.sv
module dma_cmdq_stub_tb;
  localparam int NW = 31;
  localparam logic [31:0] KEY = 32'hEE88_2266;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;

  int n_run = 0, n_fail = 0;
  logic [31:0] m_word [NW];
  logic m_hold, m_irq;

  always #2.5 clk = ~clk;

  dma_cmdq_stub u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int w);
    case (w)
      5: return "R2";
      6: return "R3";
      7: return "R4";
      8: return "R7";
      9: return "R8";
      default: return (w >= NW) ? "R10" : "R9";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NW; i++) m_word[i] = '0;
    m_word[9] = 32'hF800_0000;
    m_hold = 1'b0;
    m_irq  = 1'b0;
  endtask

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    int w;
    w = int'(a[11:2]);
    if (w >= NW) return;
    case (w)
      5: m_word[5] = d & 32'h0003_FFFF;
      6: begin
        m_word[6] = d & 32'h0003_FFFF;
        m_word[7] = m_word[6];
        if (m_hold) m_hold = 1'b0;
        else begin
          m_word[9][5:4] = 2'b11;
          if (m_word[8][4] | m_word[8][5]) m_irq = 1'b1;
        end
      end
      7: if (d == KEY) m_hold = 1'b1;
      8: m_word[8] = d & 32'hBFEF_F07F;
      9: if (d[4] | d[5]) begin m_word[9][5:4] = 2'b00; m_irq = 1'b0; end
      default: m_word[w] = d;
    endcase
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    model_write(a, d);
    check("R6 irq level", {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic bus_read_check(input logic [11:0] a);
    int w;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    w = int'(a[11:2]);
    check("R11 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    check(tag_of(w), rsp_rdata, (w < NW) ? m_word[w] : 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd1234);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset image
    check("R1 irq", {31'b0, irq}, 32'd0);
    check("R11 idle", {31'b0, rsp_valid}, 32'd0);
    check("R11 ready", {31'b0, req_ready}, 32'd1);
    for (int w = 0; w < NW; w++) bus_read_check(12'(w * 4));
    bus_read_check(12'h024);

    // R2 / R3: masking and pointer copy
    bus_write(12'h014, 32'hFFFF_FFFF); bus_read_check(12'h014);
    bus_write(12'h018, 32'h1234_5678); bus_read_check(12'h018); bus_read_check(12'h01C);
    check("R5 status set", m_word[9], 32'hF800_0030);
    bus_read_check(12'h024);
    // R6: not enabled -> irq low
    check("R6 disabled", {31'b0, irq}, 32'd0);

    // R8: status write without bits 4/5 ignored, then clear
    bus_write(12'h024, 32'hFFFF_FFCF); bus_read_check(12'h024);
    bus_write(12'h024, 32'h0000_0010); bus_read_check(12'h024);

    // R7 then R6 enabled
    bus_write(12'h020, 32'hFFFF_FFFF); bus_read_check(12'h020);
    bus_write(12'h018, 32'h0000_0042);
    check("R6 raised", {31'b0, irq}, 32'd1);
    // R4 / R5: magic suppresses only the next update
    bus_write(12'h024, 32'h0000_0020);
    check("R8 dropped", {31'b0, irq}, 32'd0);
    bus_write(12'h01C, 32'h0000_1111); bus_read_check(12'h01C);
    bus_write(12'h01C, KEY); bus_read_check(12'h01C);
    bus_write(12'h018, 32'h0000_0077);
    check("R5 suppressed", {31'b0, irq}, 32'd0);
    bus_read_check(12'h024); bus_read_check(12'h01C);
    bus_write(12'h018, 32'h0000_0078);
    check("R5 one-shot", {31'b0, irq}, 32'd1);

    // R9 / R10
    bus_write(12'h010, 32'hDEAD_BEEF); bus_read_check(12'h010);
    bus_write(12'h07C, 32'hCAFE_F00D); bus_read_check(12'h07C);
    bus_write(12'hFFC, 32'h1357_9BDF); bus_read_check(12'hFFC);

    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [11:0] a;
      logic [31:0] d;
      int pick;
      pick = int'($urandom_range(0, 9));
      if (pick < 5)      a = 12'h010 + 12'(4 * $urandom_range(1, 5));
      else if (pick < 8) a = 12'(4 * $urandom_range(0, NW - 1));
      else               a = 12'(4 * $urandom_range(NW, 1023));
      d = ($urandom_range(0, 5) == 0) ? KEY : $urandom;
      if ($urandom_range(0, 1) == 1) bus_write(a, d);
      else bus_read_check(a);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule